// File: doc/BRIEF.md
# Per-Column Polarity Profiler for a Precharged Read-Only Array

The block decides, one bit position at a time, whether a column of a precharged read-only array should be stored inverted so that most reads leave the bitlines at their precharge level. During a training window it watches a trace of logical read words. For each column it counts how many accepted words hold the level opposite to the precharge value. It also counts the words accepted in the window.

When training is closed, the block chooses a whole-plane polarity first, from the total of all unconforming bits. It then chooses a per-column refinement mask on top of that plane polarity, and freezes both. A one-stage output path models the fixed inverting or non-inverting output buffers. A raw word read from the array comes back corrected by XOR with the combined flip pattern.

Top module: `vstrip_profiler`

## Requirements
- R1: After synchronous reset, `col_mask_o` and `plane_inv_o` are 0, and `rd_valid_o` and `rd_data_o` are 0.
- R2: A cycle with `train_start_i` high clears the sample count and every column count and opens the training window. A sample valid in that same cycle is counted as the first sample. A `train_done_i` in that same cycle is ignored and training stays open.
- R3: `train_done_i` while no training window is open has no effect on `col_mask_o` or `plane_inv_o`. Samples offered while idle are not counted.
- R4: A sample bit is unconforming when it differs from the precharge level `PRECHARGE` (default 1, so a 0 bit is unconforming). Each column count is the number of accepted samples whose bit at that position is unconforming, and it never exceeds the sample count.
- R5: At commit, `plane_inv_o` becomes 1 exactly when 2 x (sum of all column counts) > (sample count) x `DATA_W`. An exact tie gives 0.
- R6: At commit, for column c, let u = count[c] when the plane bit is 0, or u = samples − count[c] when it is 1. Bit c of `col_mask_o` becomes 1 exactly when 2u > samples. An exact tie gives 0.
- R7: The sample count stops at 2^`CNT_W` − 1. Once there, further samples are ignored (no column count changes) until the next `train_start_i`.
- R8: `col_mask_o` and `plane_inv_o` change only on the clock edge of an accepted `train_done_i` (training open, no `train_start_i`). A sample valid in that same cycle is included in the decision.
- R9: One cycle after `rd_valid_i`, `rd_valid_o` is 1 and `rd_data_o` = `rd_raw_i` XOR ({`DATA_W`{`plane_inv_o`}} XOR `col_mask_o`), using the values held when the read was issued. Without `rd_valid_i`, `rd_valid_o` is 0 and `rd_data_o` holds.
- R10: Closing a training window with zero accepted samples yields `plane_inv_o` = 0 and `col_mask_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| train_start_i | input | 1 | Pulse: clear counts and open training |
| train_done_i | input | 1 | Pulse: close training and commit decisions |
| sample_valid_i | input | 1 | Trace word on `sample_data_i` is valid |
| sample_data_i | input | DATA_W | Logical read word from the trace |
| col_mask_o | output | DATA_W | Frozen per-column refinement mask |
| plane_inv_o | output | 1 | Frozen whole-plane polarity |
| rd_valid_i | input | 1 | Raw array read is valid |
| rd_raw_i | input | DATA_W | Raw word as stored in the array |
| rd_valid_o | output | 1 | Corrected read is valid |
| rd_data_o | output | DATA_W | Raw word corrected by the flip pattern |

## Verification
The two functions that can meet in one cycle are sample accumulation and the commit of the decision. The same holds for the clear of the counts and the first sample. The bench drives a trace word in the same cycle as `train_done_i`. The trace is chosen so that its inclusion turns a tied column into an inverted one, and the frozen mask is compared with a bench model that counts that word. It likewise drives a sample together with `train_start_i`, and `train_start_i` together with `train_done_i`. It judges from the committed polarity whether the sample was counted and whether the window stayed open.

// File: rtl/vsp_pkg.sv
package vsp_pkg;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_TRAIN = 1'b1
    } phase_e;

    typedef struct packed {
        logic clear;
        logic accept;
        logic commit;
    } train_ctl_t;

    // Strict majority test: 2*part > whole
    function automatic logic more_than_half(input logic [31:0] part,
                                            input logic [31:0] whole);
        return {part, 1'b0} > {1'b0, whole};
    endfunction

endpackage

// File: rtl/vsp_train_ctl.sv
module vsp_train_ctl
    import vsp_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             done_i,
    input  logic             valid_i,
    output train_ctl_t       ctl_o,
    output logic [CNT_W-1:0] n_q_o,
    output logic [CNT_W-1:0] n_next_o
);
    localparam logic [CNT_W-1:0] N_MAX = {CNT_W{1'b1}};

    phase_e           phase_q, phase_d;
    logic [CNT_W-1:0] n_q, n_d;
    logic             full;

    assign full = (n_q == N_MAX);

    always_comb begin
        ctl_o.clear  = start_i;
        ctl_o.accept = valid_i & (start_i | ((phase_q == PH_TRAIN) & ~full));
        ctl_o.commit = done_i & (phase_q == PH_TRAIN) & ~start_i;
    end

    always_comb begin
        if (ctl_o.clear) begin
            n_d = CNT_W'(ctl_o.accept);
        end else if (ctl_o.accept) begin
            n_d = n_q + CNT_W'(1);
        end else begin
            n_d = n_q;
        end
    end

    always_comb begin
        phase_d = phase_q;
        if (ctl_o.clear) begin
            phase_d = PH_TRAIN;
        end else if (ctl_o.commit) begin
            phase_d = PH_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            n_q     <= '0;
        end else begin
            phase_q <= phase_d;
            n_q     <= n_d;
        end
    end

    assign n_q_o    = n_q;
    assign n_next_o = n_d;

    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (n_q == N_MAX && !start_i) |=> (n_q == N_MAX));

    // R2
    clear_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !valid_i) |=> (n_q == '0));

    // R3
    idle_no_count_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !start_i) |=> $stable(n_q));

endmodule

// File: rtl/vsp_col_counter.sv
module vsp_col_counter #(
    parameter int unsigned CNT_W     = 8,
    parameter logic        PRECHARGE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             accept_i,
    input  logic             bit_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_next_o
);
    localparam logic [CNT_W-1:0] C_MAX = {CNT_W{1'b1}};

    logic             hit;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign hit = accept_i & (bit_i != PRECHARGE);

    always_comb begin
        if (clear_i) begin
            cnt_d = CNT_W'(hit);
        end else if (hit && cnt_q != C_MAX) begin
            cnt_d = cnt_q + CNT_W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_q_o    = cnt_q;
    assign cnt_next_o = cnt_d;

endmodule

// File: rtl/vsp_decide.sv
module vsp_decide
    import vsp_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 8
) (
    input  logic [DATA_W-1:0][CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0]             n_i,
    output logic                         plane_o,
    output logic [DATA_W-1:0]            mask_o
);
    localparam int unsigned SUM_W = CNT_W + $clog2(DATA_W) + 1;

    logic [SUM_W-1:0] total;
    logic [SUM_W-1:0] all_bits;

    always_comb begin
        total = '0;
        for (int c = 0; c < DATA_W; c++) begin
            total = total + SUM_W'(cnt_i[c]);
        end
    end

    assign all_bits = SUM_W'(n_i) * SUM_W'(DATA_W);
    assign plane_o  = more_than_half(32'(total), 32'(all_bits));

    for (genvar c = 0; c < DATA_W; c++) begin : g_col
        logic [CNT_W-1:0] adj;
        assign adj       = plane_o ? (n_i - cnt_i[c]) : cnt_i[c];
        assign mask_o[c] = more_than_half(32'(adj), 32'(n_i));
    end

endmodule

// File: rtl/vsp_out_stage.sv
module vsp_out_stage #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] raw_i,
    input  logic [DATA_W-1:0] flip_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                data_o <= raw_i ^ flip_i;
            end
        end
    end

endmodule

// File: rtl/vstrip_profiler.sv
module vstrip_profiler
    import vsp_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CNT_W     = 8,
    parameter logic        PRECHARGE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              train_start_i,
    input  logic              train_done_i,
    input  logic              sample_valid_i,
    input  logic [DATA_W-1:0] sample_data_i,
    output logic [DATA_W-1:0] col_mask_o,
    output logic              plane_inv_o,
    input  logic              rd_valid_i,
    input  logic [DATA_W-1:0] rd_raw_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);
    train_ctl_t                   ctl;
    logic [CNT_W-1:0]             n_q, n_next;
    logic [DATA_W-1:0][CNT_W-1:0] cnt_q, cnt_next;
    logic                         plane_d, plane_q;
    logic [DATA_W-1:0]            mask_d, mask_q;

    vsp_train_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (train_start_i),
        .done_i   (train_done_i),
        .valid_i  (sample_valid_i),
        .ctl_o    (ctl),
        .n_q_o    (n_q),
        .n_next_o (n_next)
    );

    for (genvar c = 0; c < DATA_W; c++) begin : g_cnt
        vsp_col_counter #(.CNT_W(CNT_W), .PRECHARGE(PRECHARGE)) u_col (
            .clk        (clk),
            .rst        (rst),
            .clear_i    (ctl.clear),
            .accept_i   (ctl.accept),
            .bit_i      (sample_data_i[c]),
            .cnt_q_o    (cnt_q[c]),
            .cnt_next_o (cnt_next[c])
        );

        // R4
        col_bound_chk: assert property (@(posedge clk) disable iff (rst)
            cnt_q[c] <= n_q);
    end

    vsp_decide #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dec (
        .cnt_i   (cnt_next),
        .n_i     (n_next),
        .plane_o (plane_d),
        .mask_o  (mask_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            plane_q <= 1'b0;
            mask_q  <= '0;
        end else if (ctl.commit) begin
            plane_q <= plane_d;
            mask_q  <= mask_d;
        end
    end

    assign col_mask_o  = mask_q;
    assign plane_inv_o = plane_q;

    vsp_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .valid_i (rd_valid_i),
        .raw_i   (rd_raw_i),
        .flip_i  ({DATA_W{plane_q}} ^ mask_q),
        .valid_o (rd_valid_o),
        .data_o  (rd_data_o)
    );

    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(train_done_i && !train_start_i && ctl.accept == ctl.accept && u_ctl.phase_q == PH_TRAIN)
        |=> ($stable(col_mask_o) && $stable(plane_inv_o)));

    // R9
    rd_path_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid_i |=> (rd_valid_o &&
            ((rd_data_o ^ $past(rd_raw_i)) == ({DATA_W{$past(plane_inv_o)}} ^ $past(col_mask_o)))));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid_i |=> (!rd_valid_o && $stable(rd_data_o)));

endmodule

// File: tb/vstrip_profiler_tb.sv
`timescale 1ns/1ps
module vstrip_profiler_tb;
    localparam int W    = 16;
    localparam int MAXN = 255;

    logic         clk = 1'b0;
    logic         rst;
    logic         train_start_i, train_done_i, sample_valid_i;
    logic [W-1:0] sample_data_i;
    logic [W-1:0] col_mask_o;
    logic         plane_inv_o;
    logic         rd_valid_i;
    logic [W-1:0] rd_raw_i;
    logic         rd_valid_o;
    logic [W-1:0] rd_data_o;

    always #2.5 clk = ~clk;

    vstrip_profiler #(.DATA_W(W), .CNT_W(8), .PRECHARGE(1'b1)) u_dut (
        .clk(clk), .rst(rst),
        .train_start_i(train_start_i), .train_done_i(train_done_i),
        .sample_valid_i(sample_valid_i), .sample_data_i(sample_data_i),
        .col_mask_o(col_mask_o), .plane_inv_o(plane_inv_o),
        .rd_valid_i(rd_valid_i), .rd_raw_i(rd_raw_i),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // bench model
    int           m_n;
    int           m_cnt [W];
    logic [W-1:0] m_mask;
    logic         m_plane;
    bit           m_train;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic void model_commit();
        int total = 0;
        for (int c = 0; c < W; c++) total += m_cnt[c];
        m_plane = (2 * total > m_n * W);
        for (int c = 0; c < W; c++) begin
            int u;
            u = m_plane ? (m_n - m_cnt[c]) : m_cnt[c];
            m_mask[c] = (2 * u > m_n);
        end
    endfunction

    task automatic cyc(input logic st, input logic dn, input logic sv, input logic [W-1:0] sd);
        bit was_train;
        bit acc;
        was_train = m_train;
        train_start_i  = st;
        train_done_i   = dn;
        sample_valid_i = sv;
        sample_data_i  = sd;
        if (st) begin
            m_n = 0;
            for (int c = 0; c < W; c++) m_cnt[c] = 0;
            m_train = 1;
        end
        acc = sv && (st || (was_train && m_n < MAXN));
        if (acc) begin
            m_n++;
            for (int c = 0; c < W; c++) if (sd[c] == 1'b0) m_cnt[c]++;
        end
        if (dn && was_train && !st) begin
            model_commit();
            m_train = 0;
        end
        @(negedge clk);
        train_start_i  = 1'b0;
        train_done_i   = 1'b0;
        sample_valid_i = 1'b0;
        sample_data_i  = '0;
    endtask

    task automatic check_state(input string req);
        chk(col_mask_o == m_mask, {req, " mask"}, 32'(col_mask_o), 32'(m_mask));
        chk(plane_inv_o == m_plane, {req, " plane"}, 32'(plane_inv_o), 32'(m_plane));
    endtask

    task automatic do_read(input logic [W-1:0] raw);
        logic [W-1:0] exp;
        logic [W-1:0] held;
        exp = raw ^ ({W{m_plane}} ^ m_mask);
        rd_valid_i = 1'b1;
        rd_raw_i   = raw;
        @(negedge clk);
        rd_valid_i = 1'b0;
        rd_raw_i   = ~raw;
        chk(rd_valid_o == 1'b1, "R9 rd_valid", 32'(rd_valid_o), 32'd1);
        chk(rd_data_o == exp, "R9 rd_data", 32'(rd_data_o), 32'(exp));
        held = rd_data_o;
        @(negedge clk);
        chk(rd_valid_o == 1'b0 && rd_data_o == held, "R9 hold", 32'(rd_data_o), 32'(held));
    endtask

    function automatic logic [W-1:0] rand_word(input int prob [W]);
        logic [W-1:0] d;
        for (int c = 0; c < W; c++) d[c] = !(int'($urandom % 100) < prob[c]);
        return d;
    endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed1234));
        rst = 1'b1;
        train_start_i = 0; train_done_i = 0; sample_valid_i = 0; sample_data_i = '0;
        rd_valid_i = 0; rd_raw_i = '0;
        m_n = 0; m_mask = '0; m_plane = 0; m_train = 0;
        for (int c = 0; c < W; c++) m_cnt[c] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(col_mask_o == '0 && plane_inv_o == 1'b0, "R1 polarity", {15'd0, plane_inv_o, col_mask_o}, 32'd0);
        chk(rd_valid_o == 1'b0 && rd_data_o == '0, "R1 read port", {15'd0, rd_valid_o, rd_data_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R3: done while idle
        cyc(0, 1, 1, 16'h0000);
        check_state("R3 idle done");

        // R10: empty window
        cyc(1, 0, 0, '0);
        cyc(0, 1, 0, '0);
        check_state("R10 empty");

        // R4 / R5: all-zero trace, every bit unconforming
        cyc(1, 0, 0, '0);
        repeat (5) cyc(0, 0, 1, 16'h0000);
        cyc(0, 1, 0, '0);
        check_state("R4 R5 all-zero");
        do_read(16'h1234);

        // R3: done while idle keeps the committed state, idle samples uncounted
        cyc(0, 0, 1, 16'hFFFF);
        cyc(0, 1, 0, '0);
        check_state("R3 idle after commit");

        // R6 tie with plane set: cols 0-7 at 2 of 4
        cyc(1, 0, 0, '0);
        cyc(0, 0, 1, 16'h0000);
        cyc(0, 0, 1, 16'h0000);
        cyc(0, 0, 1, 16'h00FF);
        cyc(0, 0, 1, 16'hFFFF);
        cyc(0, 1, 0, '0);
        check_state("R6 tie plane1");
        chk(plane_inv_o == 1'b1 && col_mask_o == '0, "R6 tie literal", {15'd0, plane_inv_o, col_mask_o}, 32'h0001_0000);

        // R5 / R6 global and column tie at plane 0
        cyc(1, 0, 0, '0);
        cyc(0, 0, 1, 16'h0000);
        cyc(0, 1, 1, 16'hFFFF);
        check_state("R5 R6 tie plane0");

        // R6 single column inverted with plane 0
        cyc(1, 0, 0, '0);
        repeat (3) cyc(0, 0, 1, 16'hFFF7);
        cyc(0, 0, 1, 16'hFFFF);
        cyc(0, 1, 0, '0);
        check_state("R6 column mask");
        do_read(16'hA5A5);

        // R5 / R6 plane set, column 0 refined back
        cyc(1, 0, 0, '0);
        repeat (4) cyc(0, 0, 1, 16'h0001);
        cyc(0, 1, 0, '0);
        check_state("R5 R6 refine");
        do_read(16'h0F0F);

        // R8: sample in the same cycle as done is included
        cyc(1, 0, 0, '0);
        cyc(0, 0, 1, 16'hFFFF);
        cyc(0, 0, 1, 16'hFFF0);
        cyc(0, 1, 1, 16'hFFF0);
        check_state("R8 same-cycle sample");
        chk(col_mask_o == 16'h000F, "R8 literal", 32'(col_mask_o), 32'h000F);

        // R2: sample on the start cycle counts
        cyc(1, 0, 1, 16'h0000);
        cyc(0, 1, 0, '0);
        check_state("R2 start sample");

        // R2: start and done together -> stays training
        cyc(1, 0, 0, '0);
        cyc(0, 0, 1, 16'hFFFF);
        cyc(1, 1, 0, '0);
        check_state("R2 start+done no commit");
        cyc(0, 0, 1, 16'h7FFF);
        cyc(0, 1, 0, '0);
        check_state("R2 window kept open");

        // R7: saturation freezes counts
        cyc(1, 0, 0, '0);
        repeat (100) cyc(0, 0, 1, 16'hFFFE);
        repeat (155) cyc(0, 0, 1, 16'hFFFF);
        repeat (200) cyc(0, 0, 1, 16'hFFFE);
        cyc(0, 1, 0, '0);
        check_state("R7 saturation");

        // random trainings
        for (int r = 0; r < 8; r++) begin
            int prob [W];
            int len;
            for (int c = 0; c < W; c++) prob[c] = int'($urandom % 101);
            len = 1 + int'($urandom % 250);
            cyc(1, 0, ($urandom % 2) == 0, rand_word(prob));
            for (int i = 0; i < len; i++) begin
                cyc(0, 0, ($urandom % 4) != 0, rand_word(prob));
            end
            cyc(0, 1, ($urandom % 2) == 0, rand_word(prob));
            check_state("R4 R5 R6 random");
            for (int k = 0; k < 3; k++) do_read(16'($urandom));
        end

        finish_run();
    end
endmodule